// File: doc/BRIEF.md
# Serial Receiver with Sticky Framing Error

This block is the receive half of a classic microcontroller serial port. It accepts the asynchronous line and a 16x oversampling tick from an external baud generator. It assembles frames of 8 or 9 data bits and presents the result through a byte-wide control register and a separate data byte. Software polls or takes an interrupt on the receive-complete flag, reads the data, and writes the flag back to zero before the next frame can be taken.

An external enable input turns on stop-bit checking. While it is set, a stop bit sampled as 0 raises a framing-error flag that stays set until software clears it. The enable also moves the receive-complete event from the last data bit to the stop bit. The top bit of the control register has two meanings, chosen by the enable. With the enable low it is the mode bit. With the enable high it is the framing-error flag. The mode bit keeps its own storage, so its value is not lost while the error flag is shown.

Top module: `uart_rx_fe`

## Requirements
- R1: Control register bit map, from bit 0 upward: 0 receive-complete (RI), 1 TI, 2 RB8, 3 TB8, 4 REN, 5 SM2, 6 SM1, 7 SM0 or framing error. TI, TB8 and SM2 are plain read/write storage. The frame format comes from {SM0,SM1}: 01 gives 8 data bits, 10 and 11 give 9 data bits, and 00 leaves the receiver inactive.
- R2: While REN is 0, no frame is received, RI does not rise and the data byte does not change.
- R3: A frame is a start bit, then 8 data bits sent LSB first, then (9-bit formats only) a ninth bit, then a stop bit. Each bit is the majority of three samples, taken at ticks 7, 8 and 9 of its 16-tick period. The data bits go to the data byte and the ninth bit goes to RB8. The 8-bit format leaves RB8 unchanged.
- R4: A frame begins on a high-to-low change of the line seen between ticks. If the start bit's majority is 1, the receiver returns to idle and RI does not rise.
- R5: Bits are numbered from 0 for the start bit. The first tick at which the line is low is tick 0 of bit 0. With checking off, RI rises on the clock of tick 16*L+9, where L is 8 (8-bit format) or 9 (9-bit formats). With checking on, RI rises at 16*(L+1)+9, the stop-bit sample.
- R6: With checking on, a stop-bit majority of 0 sets the framing-error flag. With checking off, a bad stop bit sets nothing.
- R7: The framing-error flag is sticky. Later frames with good stop bits leave it set. Only a reset, or a write of 0 to bit 7 while checking is on, clears it.
- R8: Bit 7 reads and writes SM0 while checking is off, and the framing-error flag while checking is on. SM0 keeps its value across writes to the flag and always selects the frame format.
- R9: RI stays set until software writes 0 to it. A frame that completes while RI is set is dropped: the data byte and RB8 are unchanged and RI does not rise again.
- R10: After reset the control register reads 0x00 and the data byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-clock pulse at 16 times the bit rate |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| fe_chk_en_i | input | 1 | Enables stop-bit checking and selects the meaning of bit 7 |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read value |
| rx_data_o | output | 8 | Last accepted data byte |

## Verification
The line passes through a two-flop synchronizer before sampling. Every line change is therefore driven on the falling clock edge right after a tick, which leaves four clocks before the next tick. RI and the data byte are registered on the clock that carries the sample tick. The bench takes the tick index at the next falling edge and compares it with the start tick plus 16 times the bit number plus 9. Register writes take effect on the next rising edge. Reads are combinational, so each readback is sampled on the falling edge after the write strobe drops. Framing-error, RB8 and data checks wait until the whole frame and four idle ticks have passed.

// File: rtl/uart_rx_fe_pkg.sv
package uart_rx_fe_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  // control register bit positions
  localparam int unsigned CB_RI   = 0;
  localparam int unsigned CB_TI   = 1;
  localparam int unsigned CB_RB8  = 2;
  localparam int unsigned CB_TB8  = 3;
  localparam int unsigned CB_REN  = 4;
  localparam int unsigned CB_SM2  = 5;
  localparam int unsigned CB_SM1  = 6;
  localparam int unsigned CB_TOP  = 7;
endpackage

// File: rtl/uart_rx_fe_sampler.sv
module uart_rx_fe_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  output logic line_o,
  output logic maj_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      if (tick_i) hist_q <= {hist_q[0], line_o};
    end
  end

  assign line_o = sync_q[SYNC_STAGES-1];
  // on the third sample tick: hist_q[1], hist_q[0] are the two earlier samples
  assign maj_o  = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_o) | (hist_q[0] & line_o);
endmodule

// File: rtl/uart_rx_fe_fsm.sv
module uart_rx_fe_fsm
  import uart_rx_fe_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 maj_i,
  input  logic                 enable_i,
  input  logic                 nine_bit_i,
  input  logic                 chk_en_i,
  output logic                 done_o,
  output logic                 fe_set_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ninth_o
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int IW = $clog2(DATA_BITS + 3);
  localparam logic [CW-1:0] SAMPLE_PT = CW'(OVERSAMPLE / 2 + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [IW-1:0] IDX_MSB   = IW'(DATA_BITS);
  localparam logic [IW-1:0] IDX_NINTH = IW'(DATA_BITS + 1);
  localparam logic [IW-1:0] IDX_STOP8 = IW'(DATA_BITS + 1);
  localparam logic [IW-1:0] IDX_STOP9 = IW'(DATA_BITS + 2);

  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic                 prev_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 ninth_q;

  logic [IW-1:0] last_idx, stop_idx;
  logic          at_sample, is_stop;

  assign last_idx  = nine_bit_i ? IDX_NINTH : IDX_MSB;
  assign stop_idx  = nine_bit_i ? IDX_STOP9 : IDX_STOP8;
  assign at_sample = (state_q == RX_FRAME) && enable_i && tick_i && (cnt_q == SAMPLE_PT);
  assign is_stop   = at_sample && (idx_q == stop_idx);
  assign done_o    = chk_en_i ? is_stop : (at_sample && (idx_q == last_idx));
  assign fe_set_o  = is_stop && chk_en_i && !maj_i;
  // last data bit is being sampled in this cycle: merge it in
  assign data_o    = (idx_q == IDX_MSB) ? {maj_i, shift_q[DATA_BITS-1:1]} : shift_q;
  assign ninth_o   = (nine_bit_i && idx_q == IDX_NINTH) ? maj_i : ninth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      shift_q <= '0;
      ninth_q <= 1'b0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (tick_i) begin
            prev_q <= line_i;
            if (enable_i && prev_q && !line_i) begin
              state_q <= RX_FRAME;
              cnt_q   <= CW'(1);
              idx_q   <= '0;
            end
          end
        end
        RX_FRAME: begin
          if (!enable_i) begin
            state_q <= RX_IDLE;
            prev_q  <= 1'b0;
          end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST_TICK) ? '0 : cnt_q + CW'(1);
            if (cnt_q == LAST_TICK) idx_q <= idx_q + IW'(1);
            if (at_sample) begin
              if (idx_q == '0) begin
                if (maj_i) begin
                  state_q <= RX_IDLE;
                  prev_q  <= 1'b1;
                end
              end else if (idx_q == stop_idx) begin
                state_q <= RX_IDLE;
                prev_q  <= maj_i;
              end else if (idx_q <= IDX_MSB) begin
                shift_q <= {maj_i, shift_q[DATA_BITS-1:1]};
              end else if (nine_bit_i && idx_q == IDX_NINTH) begin
                ninth_q <= maj_i;
              end
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fe_ctrl.sv
module uart_rx_fe_ctrl
  import uart_rx_fe_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 chk_en_i,
  input  logic                 done_i,
  input  logic                 fe_set_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 ninth_i,
  output logic [7:0]           rdata_o,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 ren_o,
  output logic                 sm0_o,
  output logic                 sm1_o,
  output logic                 fe_o
);
  logic ri_q, ti_q, rb8_q, tb8_q, ren_q, sm2_q, sm1_q, sm0_q, fe_q;
  logic [DATA_BITS-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ri_q, ti_q, rb8_q, tb8_q, ren_q, sm2_q, sm1_q, sm0_q, fe_q} <= '0;
      rx_q <= '0;
    end else begin
      if (wr_i) begin
        ri_q  <= wdata_i[CB_RI];
        ti_q  <= wdata_i[CB_TI];
        rb8_q <= wdata_i[CB_RB8];
        tb8_q <= wdata_i[CB_TB8];
        ren_q <= wdata_i[CB_REN];
        sm2_q <= wdata_i[CB_SM2];
        sm1_q <= wdata_i[CB_SM1];
        if (chk_en_i) fe_q  <= wdata_i[CB_TOP];
        else          sm0_q <= wdata_i[CB_TOP];
      end
      // receiver events override a same-cycle write
      if (done_i && !ri_q) begin
        ri_q <= 1'b1;
        rx_q <= data_i;
        if (sm0_q) rb8_q <= ninth_i;
      end
      if (fe_set_i) fe_q <= 1'b1;
    end
  end

  assign rdata_o   = {chk_en_i ? fe_q : sm0_q, sm1_q, sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign rx_data_o = rx_q;
  assign ren_o     = ren_q;
  assign sm0_o     = sm0_q;
  assign sm1_o     = sm1_q;
  assign fe_o      = fe_q;
endmodule

// File: rtl/uart_rx_fe.sv
module uart_rx_fe #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick16_i,
  input  logic                 rxd_i,
  input  logic                 fe_chk_en_i,
  input  logic                 reg_wr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  output logic [DATA_BITS-1:0] rx_data_o
);
  logic line_s, maj_s;
  logic done_s, fe_set_s, ninth_s;
  logic [DATA_BITS-1:0] data_s;
  logic ren_q, sm0_q, sm1_q, fe_q;
  logic rx_enable;

  assign rx_enable = ren_q & (sm0_q | sm1_q);

  uart_rx_fe_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick16_i),
    .rxd_i  (rxd_i),
    .line_o (line_s),
    .maj_o  (maj_s)
  );

  uart_rx_fe_fsm #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .line_i     (line_s),
    .maj_i      (maj_s),
    .enable_i   (rx_enable),
    .nine_bit_i (sm0_q),
    .chk_en_i   (fe_chk_en_i),
    .done_o     (done_s),
    .fe_set_o   (fe_set_s),
    .data_o     (data_s),
    .ninth_o    (ninth_s)
  );

  uart_rx_fe_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .chk_en_i  (fe_chk_en_i),
    .done_i    (done_s),
    .fe_set_i  (fe_set_s),
    .data_i    (data_s),
    .ninth_i   (ninth_s),
    .rdata_o   (reg_rdata_o),
    .rx_data_o (rx_data_o),
    .ren_o     (ren_q),
    .sm0_o     (sm0_q),
    .sm1_o     (sm1_q),
    .fe_o      (fe_q)
  );
endmodule

// File: rtl/uart_rx_fe_chk.sv
module uart_rx_fe_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 chk_en_i,
  input logic                 fe_i,
  input logic                 sm0_i,
  input logic                 ri_i,
  input logic                 ren_i,
  input logic [DATA_BITS-1:0] rx_data_i
);
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_i && !(wr_i && chk_en_i)) |=> fe_i); // R7
  AST_FE_NEEDS_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fe_i && !chk_en_i && !wr_i) |=> !fe_i); // R6
  AST_SM0_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && chk_en_i) |=> $stable(sm0_i)); // R8
  AST_RI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_i && !wr_i) |=> ri_i); // R9
  AST_DATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_i && !wr_i) |=> $stable(rx_data_i)); // R9
  AST_NO_RX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren_i && !ri_i && !wr_i) |=> !ri_i); // R2
endmodule

bind uart_rx_fe uart_rx_fe_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (reg_wr_i),
  .chk_en_i  (fe_chk_en_i),
  .fe_i      (fe_q),
  .sm0_i     (sm0_q),
  .ri_i      (reg_rdata_o[0]),
  .ren_i     (ren_q),
  .rx_data_i (rx_data_o)
);

// File: tb/uart_rx_fe_tb.sv
`timescale 1ns/1ps
module uart_rx_fe_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       smod = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] rx_data_o;

  int n_chk = 0, n_err = 0;
  int tick_idx = 0, rise_cnt = 0, rise_tick = 0;
  logic [1:0] div_q = '0;
  logic ri_prev = 1'b0;
  bit   finished = 0;

  // bench model of the register
  logic m_ri, m_ti, m_rb8, m_tb8, m_ren, m_sm2, m_sm1, m_sm0, m_fe;
  logic [7:0] m_rx;

  always #2.5 clk_i = ~clk_i;

  uart_rx_fe u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick16_i    (tick16_i),
    .rxd_i       (rxd_i),
    .fe_chk_en_i (smod),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .rx_data_o   (rx_data_o)
  );

  always @(negedge clk_i) begin
    div_q    <= div_q + 2'd1;
    tick16_i <= (div_q == 2'd3);
    if (div_q == 2'd3) tick_idx <= tick_idx + 1;
  end

  always @(negedge clk_i) begin
    if (rst_ni && reg_rdata_o[0] && !ri_prev) begin
      rise_cnt  <= rise_cnt + 1;
      rise_tick <= tick_idx;
    end
    ri_prev <= reg_rdata_o[0];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_reg(input logic s);
    return {s ? m_fe : m_sm0, m_sm1, m_sm2, m_ren, m_tb8, m_rb8, m_ti, m_ri};
  endfunction

  task automatic wait_tick();
    do @(posedge clk_i); while (!tick16_i);
  endtask

  task automatic set_smod(input logic v);
    @(negedge clk_i);
    smod = v;
  endtask

  task automatic wr_ctrl(input logic [7:0] v, input string req);
    @(negedge clk_i);
    reg_wr_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    {m_sm1, m_sm2, m_ren, m_tb8, m_rb8, m_ti, m_ri} = v[6:0];
    if (smod) m_fe = v[7]; else m_sm0 = v[7];
    chk(req, reg_rdata_o, model_reg(smod));
  endtask

  task automatic read_fe(input string req);
    logic s;
    s = smod;
    set_smod(1'b1);
    @(negedge clk_i);
    chk(req, reg_rdata_o[7], m_fe);
    set_smod(s);
  endtask

  task automatic do_frame(input logic [7:0] d, input logic ninth, input logic stop,
                          input string rise_req);
    logic [10:0] bits;
    logic active, accept;
    int nb, rx_idx, rises0, start_tick;
    active = m_ren && (m_sm0 || m_sm1);
    nb = m_sm0 ? 11 : 10;
    bits = '0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    if (m_sm0) bits[9] = ninth;
    bits[nb-1] = stop;
    rx_idx = (m_sm0 ? 9 : 8) + (smod ? 1 : 0);
    accept = active && !m_ri;
    rises0 = rise_cnt;
    wait_tick();
    @(negedge clk_i);
    start_tick = tick_idx + 1;
    for (int i = 0; i < nb; i++) begin
      rxd_i = bits[i];
      repeat (16) wait_tick();
      @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (4) wait_tick();
    @(negedge clk_i);
    if (active && smod && !stop) m_fe = 1'b1;
    if (accept) begin
      m_ri = 1'b1;
      m_rx = d;
      if (m_sm0) m_rb8 = ninth;
    end
    chk(rise_req, rise_cnt - rises0, accept ? 1 : 0);
    if (accept) chk("R5 RI tick", rise_tick, start_tick + 16 * rx_idx + 9);
    chk("R3 data", rx_data_o, m_rx);
    chk("R3 RB8", reg_rdata_o[2], m_rb8);
    chk("R9 RI", reg_rdata_o[0], m_ri);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [1:0] mode;
    void'($urandom(32'd5122));
    {m_ri, m_ti, m_rb8, m_tb8, m_ren, m_sm2, m_sm1, m_sm0, m_fe} = '0;
    m_rx = '0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 reg", reg_rdata_o, 8'h00);
    chk("R10 data", rx_data_o, 8'h00);

    // plain storage bits
    wr_ctrl(8'h2A, "R1 storage");
    // receiver off: REN=0 in 8-bit format
    wr_ctrl(8'h40, "R1");
    do_frame(8'h5A, 1'b0, 1'b1, "R2 no rx when REN=0");
    // format 00 inactive
    wr_ctrl(8'h10, "R1");
    do_frame(8'h5A, 1'b0, 1'b1, "R1 format 00 inactive");

    // 8-bit, checking off
    wr_ctrl(8'h50, "R1");
    do_frame(8'hA5, 1'b1, 1'b1, "R5 8-bit check off");
    // 8-bit, checking on
    set_smod(1'b1);
    wr_ctrl(8'h50, "R9 clear RI");
    do_frame(8'h3C, 1'b0, 1'b1, "R5 8-bit check on");
    read_fe("R6 good stop");
    wr_ctrl(8'h50, "R9 clear RI");
    do_frame(8'hC3, 1'b0, 1'b0, "R6 bad stop frame");
    read_fe("R6 bad stop sets FE");
    // clear RI, keep FE, then a good frame
    wr_ctrl(8'hD0, "R7 keep FE");
    do_frame(8'h81, 1'b0, 1'b1, "R7 good frame");
    read_fe("R7 FE sticky");
    // bit 7 aliasing
    set_smod(1'b0);
    @(negedge clk_i);
    chk("R8 bit7 shows SM0", reg_rdata_o[7], 1'b0);
    set_smod(1'b1);
    wr_ctrl(8'h50, "R7 clear FE");
    read_fe("R7 FE cleared");
    set_smod(1'b0);
    wr_ctrl(8'h90, "R8 write SM0");
    set_smod(1'b1);
    @(negedge clk_i);
    chk("R8 bit7 shows FE", reg_rdata_o[7], 1'b0);
    wr_ctrl(8'h90, "R8 write FE");
    set_smod(1'b0);
    @(negedge clk_i);
    chk("R8 SM0 kept", reg_rdata_o[7], 1'b1);
    wr_ctrl(8'h50, "R8 SM0 back to 0");
    set_smod(1'b1);
    @(negedge clk_i);
    chk("R8 FE kept", reg_rdata_o[7], 1'b1);
    wr_ctrl(8'h50, "R7 clear FE");
    // bad stop with checking off
    set_smod(1'b0);
    do_frame(8'h0F, 1'b0, 1'b0, "R6 check off frame");
    read_fe("R6 no FE when off");
    // RI still set: next frame dropped
    do_frame(8'hF0, 1'b0, 1'b1, "R9 dropped frame");
    wr_ctrl(8'h50, "R9 clear RI");
    // false start
    begin
      int r0;
      r0 = rise_cnt;
      wait_tick();
      @(negedge clk_i);
      rxd_i = 1'b0;
      repeat (4) wait_tick();
      @(negedge clk_i);
      rxd_i = 1'b1;
      repeat (24) wait_tick();
      @(negedge clk_i);
      chk("R4 false start", rise_cnt - r0, 0);
      chk("R4 RI", reg_rdata_o[0], 1'b0);
    end
    do_frame(8'h66, 1'b0, 1'b1, "R4 recover");
    // 9-bit formats
    wr_ctrl(8'hD0, "R1 9-bit");
    do_frame(8'h99, 1'b1, 1'b1, "R5 9-bit check off");
    set_smod(1'b1);
    wr_ctrl(8'h90, "R1 9-bit");
    do_frame(8'h12, 1'b0, 1'b1, "R5 9-bit check on");

    // random
    for (int k = 0; k < 40; k++) begin
      mode = 2'($urandom_range(3, 1));
      set_smod(1'b0);
      wr_ctrl({mode[1], mode[0], 6'b010000}, "R1 random");
      set_smod(1'($urandom % 2));
      do_frame(8'($urandom), 1'($urandom % 2), ($urandom % 4) != 0, "R5 random");
      read_fe("R6 random");
      if ($urandom % 3 == 0) begin
        set_smod(1'b1);
        wr_ctrl({1'b0, m_sm1, 6'b010000}, "R7 random clear");
        read_fe("R7 random");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule